// File: doc/BRIEF.md
# Self-Scanning Dot Display Refresh Controller

This block keeps a single-line dot display refreshed from a frame buffer in system memory. The display has 7 dot rows and 222 columns. It has no memory of its own: each column byte must be presented on seven data lines during every display clock period. The block counts CPU cycle ticks, one every 2.5 µs, to build the display clock. That clock has a fixed, asymmetric period of 140 µs. The block also steps a column pointer once per period and sends a one-period active-low reset to mark each frame boundary.

Column bytes are read from memory without a DMA engine. When a column's byte is still wanted, the block raises a read request, and only during CPU states in which the memory bus is free. The byte is captured on the first such tick. The seven data lines are pull-down enables for open-drain drivers outside the block. They are held released (all zero) through the whole reset period and through the opening of every clock period.

Top module: `scan_refresh_ctrl`

## Requirements
- R1: A tick counter advances on each `cyc_tick` and runs 0 to 55 (56 ticks per display clock period). After reset it is 0. `disp_clk` is low while the count is 0 to 9 and high while it is 10 to 55.
- R2: The column pointer is 0x21 after reset. It advances by one at each period end (the tick taken at count 55), and after 0xFF it goes back to 0x21.
- R3: `mem_addr` is 0x20 in the upper byte and the column pointer in the lower byte, so the frame buffer occupies 0x2022 to 0x20FF.
- R4: `disp_rst_n` is low for exactly one full period (56 ticks), namely while the pointer is 0x21, and high otherwise. The first column after it is addressed at 0x2022.
- R5: `data_pd` is all zero for the whole reset period, and during counts 0 to 5 of every other period.
- R6: From count 6 to 55 of a non-reset period, `data_pd` equals bits 6:0 of the latched byte; a 1 turns that line's pull-down on.
- R7: Fetch windows are the `cpu_state` codes 3'b010 (first address cycle of an instruction), 3'b011 (halted) and 3'b000 (waiting). `mem_req` is high only in a fetch window and only while the current column's request is outstanding.
- R8: A request is raised at the start of every period except the reset period. The byte is captured on the first tick with `mem_req` high, except at count 55, and the capture clears the request.
- R9: If no capture happens in a period, the previously latched byte is held and shown again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_tick | input | 1 | One-clock pulse per 2.5 µs CPU cycle |
| cpu_state | input | 3 | CPU state code used to find free bus cycles |
| mem_rdata | input | 8 | Byte returned by memory for `mem_addr` |
| mem_req | output | 1 | Read request for the current column byte |
| mem_addr | output | 16 | Frame-buffer address of the current column |
| disp_clk | output | 1 | Asymmetric display clock |
| disp_rst_n | output | 1 | Active-low display frame reset |
| data_pd | output | 7 | Pull-down enables for the seven dot rows |

## Verification
A wrong tick count shows up within one period as a display clock edge at the wrong tick, or as data lines that leave the released state too early. A column pointer that skips or wraps wrongly shows up at once on `mem_addr`. It also moves the reset pulse, which the bench sees within one frame of about 12,500 ticks. A capture that is lost or extra leaves the wrong byte on `data_pd` from count 6 of that same period, and a stuck request shows as `mem_req` staying high after the capture tick.

// File: rtl/scan_refresh_pkg.sv
// Shared constants and helpers for the display refresh controller.
// Assumes a 3-bit CPU state code; three codes mark a free memory bus.
package scan_refresh_pkg;
    localparam logic [2:0] CS_WAIT  = 3'b000;
    localparam logic [2:0] CS_ADDR1 = 3'b010;
    localparam logic [2:0] CS_STOP  = 3'b011;

    // True when the CPU leaves the memory bus idle in this cycle.
    function automatic logic bus_free(input logic [2:0] st);
        return (st == CS_WAIT) || (st == CS_ADDR1) || (st == CS_STOP);
    endfunction
endpackage

// File: rtl/srd_timebase.sv
// Tick counter and display clock generator.
// Assumes cyc_tick is a single-clock pulse; produces the period end strobe,
// the asymmetric display clock and the data-drive window.
module srd_timebase #(
    parameter int TICKS = 56,
    parameter int LOW_TICKS = 10,
    parameter int REL_TICKS = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick,
    output logic [$clog2(TICKS)-1:0]   tcnt,
    output logic                       period_end,
    output logic                       disp_clk,
    output logic                       drive_window
);
    localparam int TW = $clog2(TICKS);
    localparam logic [TW-1:0] LAST = TW'(TICKS - 1);

    // Count ticks within one display clock period.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tcnt <= '0;
        else if (tick)
            tcnt <= (tcnt == LAST) ? '0 : tcnt + 1'b1;
    end

    // Decode period end, clock phase and the data window from the count.
    always_comb begin
        period_end   = tick && (tcnt == LAST);
        disp_clk     = (tcnt >= TW'(LOW_TICKS));
        drive_window = (tcnt >= TW'(REL_TICKS));
    end

    // R1
    tcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tcnt <= LAST);
    // R1
    clk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && tcnt == TW'(LOW_TICKS - 1)) |=> $rose(disp_clk));
endmodule

// File: rtl/srd_column.sv
// Column pointer and frame reset flag.
// Assumes step is the period end strobe; the pointer wraps from LAST back
// to the reset column, and the flag covers exactly that column's period.
module srd_column #(
    parameter int COL_W = 8,
    parameter logic [COL_W-1:0] FIRST = 8'h21,
    parameter logic [COL_W-1:0] LAST  = 8'hFF,
    parameter logic [7:0] PAGE = 8'h20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step,
    output logic [COL_W-1:0]     col,
    output logic                 blank,
    output logic                 enter_blank,
    output logic [COL_W+7:0]     addr
);
    // Steps into the reset column on this strobe.
    always_comb enter_blank = step && (col == LAST);

    // Advance the column pointer once per display clock period.
    always_ff @(posedge clk) begin
        if (!rst_n)
            col <= FIRST;
        else if (step)
            col <= (col == LAST) ? FIRST : col + 1'b1;
    end

    // Flag set by the terminal count, cleared after one full period.
    always_ff @(posedge clk) begin
        if (!rst_n)
            blank <= 1'b1;
        else if (enter_blank)
            blank <= 1'b1;
        else if (step)
            blank <= 1'b0;
    end

    // Form the frame-buffer address from the fixed page and the pointer.
    always_comb addr = {PAGE, col};

    // R2
    col_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && col == LAST) |=> (col == FIRST));
    // R4
    blank_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blank == (col == FIRST));
endmodule

// File: rtl/srd_fetch.sv
// Bus-stealing column fetch, data latch and pull-down output gating.
// Assumes the memory returns data for mem_addr in the same clock.
module srd_fetch
    import scan_refresh_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int DOTS = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               period_end,
    input  logic               enter_blank,
    input  logic               blank,
    input  logic               drive_window,
    input  logic [2:0]         cpu_state,
    input  logic [BYTE_W-1:0]  rdata,
    output logic               req_out,
    output logic [DOTS-1:0]    pd
);
    logic              req_q;
    logic              capture;
    logic [BYTE_W-1:0] latch_q;

    // Request only while outstanding and the bus is free.
    always_comb begin
        req_out = req_q && bus_free(cpu_state);
        capture = tick && req_out && !period_end;
    end

    // Raise the request at each data period start, drop it on capture.
    always_ff @(posedge clk) begin
        if (!rst_n)
            req_q <= 1'b0;
        else if (period_end)
            req_q <= !enter_blank;
        else if (capture)
            req_q <= 1'b0;
    end

    // Hold the last captured column byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            latch_q <= '0;
        else if (capture)
            latch_q <= rdata;
    end

    // Enable pull-downs only outside the release windows.
    always_comb pd = (drive_window && !blank) ? latch_q[DOTS-1:0] : '0;

    // R8
    req_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && req_out && !period_end) |=> !req_q);
    // R9
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick && req_out) |=> $stable(latch_q));
endmodule

// File: rtl/scan_refresh_ctrl.sv
// Top of the display refresh controller: timebase, column pointer and
// fetch path. Assumes one cyc_tick pulse per CPU cycle.
module scan_refresh_ctrl #(
    parameter int TICKS = 56,
    parameter int LOW_TICKS = 10,
    parameter int REL_TICKS = 6,
    parameter int DOTS = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cyc_tick,
    input  logic [2:0]   cpu_state,
    input  logic [7:0]   mem_rdata,
    output logic         mem_req,
    output logic [15:0]  mem_addr,
    output logic         disp_clk,
    output logic         disp_rst_n,
    output logic [6:0]   data_pd
);
    localparam int TW = $clog2(TICKS);

    logic [TW-1:0] tcnt;
    logic          period_end;
    logic          drive_window;
    logic [7:0]    col;
    logic          blank;
    logic          enter_blank;

    srd_timebase #(.TICKS(TICKS), .LOW_TICKS(LOW_TICKS), .REL_TICKS(REL_TICKS)) u_tb (
        .clk(clk), .rst_n(rst_n), .tick(cyc_tick), .tcnt(tcnt),
        .period_end(period_end), .disp_clk(disp_clk), .drive_window(drive_window)
    );

    srd_column u_col (
        .clk(clk), .rst_n(rst_n), .step(period_end), .col(col),
        .blank(blank), .enter_blank(enter_blank), .addr(mem_addr)
    );

    srd_fetch #(.BYTE_W(8), .DOTS(DOTS)) u_fetch (
        .clk(clk), .rst_n(rst_n), .tick(cyc_tick), .period_end(period_end),
        .enter_blank(enter_blank), .blank(blank), .drive_window(drive_window),
        .cpu_state(cpu_state), .rdata(mem_rdata), .req_out(mem_req), .pd(data_pd)
    );

    // Drive the display reset from the frame flag.
    always_comb disp_rst_n = !blank;

    // R5
    blank_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_rst_n |-> (data_pd == '0));
    // R8
    no_req_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_rst_n |-> !mem_req);
    // R5
    low_phase_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tcnt < TW'(REL_TICKS)) |-> (data_pd == '0));
endmodule

// File: tb/sim_scan_refresh_ctrl.sv
module sim_scan_refresh_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_tick = 1'b0;
    logic [2:0]  cpu_state = 3'b001;
    logic [7:0]  mem_rdata;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        disp_clk;
    logic        disp_rst_n;
    logic [6:0]  data_pd;

    int checks = 0;
    int fails = 0;

    // bench model state
    int         m_t = 0;
    logic [7:0] m_col = 8'h21;
    logic       m_req = 1'b0;
    logic [7:0] m_lat = 8'h00;

    localparam logic [2:0] ST_A1 = 3'b010;
    localparam logic [2:0] ST_HALT = 3'b011;
    localparam logic [2:0] ST_WT = 3'b000;
    localparam logic [2:0] ST_BUSY = 3'b101;

    always #10 clk = ~clk;

    assign mem_rdata = mem_addr[7:0] ^ 8'h5A;

    scan_refresh_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .cpu_state(cpu_state),
        .mem_rdata(mem_rdata), .mem_req(mem_req), .mem_addr(mem_addr),
        .disp_clk(disp_clk), .disp_rst_n(disp_rst_n), .data_pd(data_pd)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (col %0h tick %0d)", req, act, exp, m_col, m_t);
        end
    endtask

    // One CPU cycle tick with the given state, model update and port checks.
    task automatic tick_once(input logic [2:0] st);
        bit ok, cap, fin;
        logic [6:0] exp_pd;
        @(negedge clk);
        cpu_state = st;
        cyc_tick = 1'b1;
        #1;
        ok = (st == ST_A1) || (st == ST_HALT) || (st == ST_WT);
        chk(mem_req === (m_req && ok), "R7", mem_req, m_req && ok);
        cap = m_req && ok && (m_t != 55);
        fin = (m_t == 55);
        @(negedge clk);
        cyc_tick = 1'b0;
        if (cap) begin m_lat = m_col ^ 8'h5A; m_req = 1'b0; end
        if (fin) begin
            m_col = (m_col == 8'hFF) ? 8'h21 : m_col + 8'd1;
            m_req = (m_col != 8'h21);
            m_t = 0;
        end else m_t++;
        chk(disp_clk === (m_t >= 10), "R1", disp_clk, m_t >= 10);
        chk(disp_rst_n === (m_col != 8'h21), "R4", disp_rst_n, m_col != 8'h21);
        chk(mem_addr === {8'h20, m_col}, "R3", mem_addr, {8'h20, m_col});
        exp_pd = (m_col != 8'h21 && m_t >= 6) ? m_lat[6:0] : 7'h00;
        if (exp_pd == 7'h00 && (m_col == 8'h21 || m_t < 6))
            chk(data_pd === 7'h00, "R5", data_pd, 0);
        else
            chk(data_pd === exp_pd, "R6", data_pd, exp_pd);
    endtask

    task automatic run_until_t(input int t, input logic [2:0] st);
        do tick_once(st); while (m_t != t);
    endtask

    task automatic t_reset();
        @(negedge clk);
        cpu_state = ST_A1;
        #1;
        chk(disp_clk === 1'b0, "R1 reset clock low", disp_clk, 0);
        chk(mem_addr === 16'h2021, "R2 reset column", mem_addr, 16'h2021);
        chk(disp_rst_n === 1'b0, "R4 reset pulse at start", disp_rst_n, 0);
        chk(data_pd === 7'h00, "R5 reset released", data_pd, 0);
        chk(mem_req === 1'b0, "R8 no request in reset column", mem_req, 0);
    endtask

    task automatic t_first_columns();
        for (int i = 0; i < 56 * 3; i++) tick_once(ST_A1);
        chk(mem_addr === 16'h2024, "R2 step per period", mem_addr, 16'h2024);
        run_until_t(10, ST_A1);
        chk(data_pd === ((8'h24 ^ 8'h5A) & 8'h7F), "R6 column byte shown", data_pd, (8'h24 ^ 8'h5A) & 8'h7F);
    endtask

    task automatic t_other_windows();
        run_until_t(0, ST_A1);
        run_until_t(0, ST_HALT);
        run_until_t(20, ST_WT);
        chk(data_pd === ((m_col ^ 8'h5A) & 8'h7F), "R7 wait state fetch", data_pd, (m_col ^ 8'h5A) & 8'h7F);
    endtask

    task automatic t_stall();
        logic [7:0] prev;
        run_until_t(0, ST_A1);
        prev = m_lat;
        run_until_t(20, ST_BUSY);
        chk(data_pd === prev[6:0], "R9 held byte", data_pd, prev[6:0]);
        chk(mem_req === 1'b0, "R7 busy state no request", mem_req, 0);
        run_until_t(0, ST_BUSY);
    endtask

    task automatic t_late();
        logic [7:0] prev;
        run_until_t(0, ST_A1);
        prev = m_lat;
        run_until_t(30, ST_BUSY);
        chk(data_pd === prev[6:0], "R9 before late fetch", data_pd, prev[6:0]);
        tick_once(ST_A1);
        chk(data_pd === ((m_col ^ 8'h5A) & 8'h7F), "R8 late capture", data_pd, (m_col ^ 8'h5A) & 8'h7F);
        @(negedge clk); #1;
        chk(mem_req === 1'b0, "R8 request cleared", mem_req, 0);
    endtask

    task automatic t_terminal();
        logic [7:0] prev;
        run_until_t(0, ST_A1);
        prev = m_lat;
        run_until_t(55, ST_BUSY);
        tick_once(ST_A1);
        run_until_t(10, ST_BUSY);
        chk(data_pd === prev[6:0], "R8 no capture at count 55", data_pd, prev[6:0]);
        run_until_t(0, ST_A1);
    endtask

    task automatic t_wrap();
        int low;
        do tick_once(ST_A1); while (m_col != 8'h21);
        low = 1;
        chk(disp_rst_n === 1'b0, "R4 reset after 0xFF", disp_rst_n, 0);
        do begin
            tick_once(ST_A1);
            if (disp_rst_n === 1'b0) low++;
        end while (m_col != 8'h22);
        chk(low == 56, "R4 reset length", low, 56);
        chk(mem_addr === 16'h2022, "R2 first column after wrap", mem_addr, 16'h2022);
        #1;
        chk(mem_req === 1'b1, "R8 request after reset period", mem_req, 1);
        run_until_t(8, ST_A1);
        chk(data_pd === ((8'h22 ^ 8'h5A) & 8'h7F), "R6 first column data", data_pd, (8'h22 ^ 8'h5A) & 8'h7F);
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_first_columns();
        t_other_windows();
        t_stall();
        t_late();
        t_terminal();
        t_wrap();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule